// File: doc/BRIEF.md
# Serial EEPROM Write-Transaction Front End

This block is the two-wire serial-bus front end of a byte-addressed EEPROM slave, covering write transactions. It samples the clock and data lines into the core clock domain and recognises bus start and stop events. After a start it takes a device select byte. If the device-type nibble and the three hardware select bits match, it takes a two-byte word address (high byte first) and then any number of data bytes. It acknowledges by pulling an open-drain enable during the ninth clock of each byte it accepts.

Each accepted data byte is handed to a storage back end as a write strobe with its address and value. The address advances inside a fixed-size page and wraps at the page boundary. A later pulse tells the back end to either commit the collected bytes or throw them away. A write-inhibit input is watched from the start through the last address byte, and if it was ever high the data phase is refused. While the back end reports a write cycle in progress, the front end stays off the bus completely.

Top module: `eeprom_write_front`

## Requirements
- R1: A select byte whose bits [7:4] equal DEV_TYPE (default 4'b1010), whose bits [3:1] equal `hw_sel_i` and whose bit 0 (RW) is 0 is acknowledged by a low line during its ninth clock.
- R2: A select byte that does not match on bits [7:4] or [3:1] gets NoAck, and every byte after it gets NoAck until the next start.
- R3: The two bytes after an accepted write select are both acknowledged; the first forms address bits [15:8], the second bits [7:0], and the first data strobe carries that address.
- R4: With writes allowed, each data byte (received MSB first) is acknowledged and produces one `wr_strobe_o` pulse with its value. Later bytes increment only the low log2(PAGE_BYTES) address bits, which wrap to 0 while the upper bits stay fixed (default page 32 bytes).
- R5: If `wc_i` is high in any cycle from the start until the second address byte is received, that transaction's data bytes get NoAck, produce no strobe and no commit. The address bytes are still acknowledged. `wc_i` after that point has no effect.
- R6: A stop whose clock-high phase is the first clock after a data byte's acknowledge, in a transaction with at least one strobe, gives one `commit_o` pulse. A stop in any other slot gives `abort_o` instead if bytes were strobed, and neither pulse if none were. Commit and abort never coincide.
- R7: A repeated start aborts the transfer in progress (an `abort_o` pulse if bytes were strobed, no commit) and the next byte is treated as a fresh select byte.
- R8: While `busy_i` is high, `sda_oe_o` stays low, and no strobe or commit is issued. A start seen while busy is ignored until the next start.
- R9: A matching select byte with RW=1 is acknowledged; after it, no byte is acknowledged or strobed until the next start.
- R10: `sda_oe_o` is low after reset and during the eight data bits of every byte; it rises only after the falling clock edge that ends bit 8 and falls after the falling edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| wc_i | input | 1 | Write inhibit, active high |
| busy_i | input | 1 | Back end is running an internal write cycle |
| hw_sel_i | input | 3 | Hardware select bits matched against select bits [3:1] |
| sda_oe_o | output | 1 | Pull data line low when 1 (open drain) |
| wr_strobe_o | output | 1 | One-cycle pulse: accepted data byte |
| wr_addr_o | output | ADDR_W | Address of the strobed byte |
| wr_data_o | output | 8 | Value of the strobed byte |
| commit_o | output | 1 | One-cycle pulse: start the internal write of the strobed bytes |
| abort_o | output | 1 | One-cycle pulse: drop the strobed bytes |

## Verification
The hardest case to reach from the ports is a stop that falls exactly in the first clock after a data acknowledge, compared with a stop a few bits later. Both look like an ordinary stop on the lines. The bench drives a bus master whose stop task first raises the clock with data low and then raises data. That clock edge is counted as a bit, so the bench can place a stop either right after an acknowledge or after a chosen number of extra bits, and then check whether a commit or an abort pulse came out. The write-inhibit window is probed at both of its ends: high only during the high address byte, and raised only after the low address byte has been acknowledged.

// File: rtl/ee_wr_pkg.sv
package ee_wr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_RD
  } wr_state_e;
endpackage

// File: rtl/ee_bus_sampler.sv
module ee_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic [SYNC_STAGES-1:0] scl_sync_d, sda_sync_d;
  logic scl_q, sda_q, scl_s;

  always_comb begin
    scl_sync_d = {scl_sync[SYNC_STAGES-2:0], scl_i};
    sda_sync_d = {sda_sync[SYNC_STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= scl_sync_d;
      sda_sync <= sda_sync_d;
      scl_q    <= scl_sync[SYNC_STAGES-1];
      sda_q    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_sync[SYNC_STAGES-1];
  assign sda_s     = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & ~sda_s & sda_q;
  assign stop_det  = scl_s & scl_q & sda_s & ~sda_q;
endmodule

// File: rtl/ee_bit_shifter.sv
module ee_bit_shifter #(
  parameter int BITS = 8,
  localparam int CW = $clog2(BITS + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            frame_rst,
  input  logic            sda_s,
  output logic [BITS-1:0] byte_q,
  output logic            byte_done,
  output logic [CW-1:0]   slot_cnt
);
  localparam logic [CW-1:0] LAST_DATA = CW'(BITS - 1);
  localparam logic [CW-1:0] ACK_WAIT  = CW'(BITS);
  localparam logic [CW-1:0] ACK_HELD  = CW'(BITS + 1);

  logic [BITS-1:0] shreg_d;
  logic [CW-1:0]   cnt_d;
  logic            done_d;

  always_comb begin
    shreg_d = byte_q;
    cnt_d   = slot_cnt;
    done_d  = 1'b0;
    if (frame_rst) begin
      cnt_d = '0;
    end else if (scl_rise) begin
      if (slot_cnt < ACK_WAIT) begin
        shreg_d = {byte_q[BITS-2:0], sda_s};
        cnt_d   = slot_cnt + 1'b1;
        done_d  = (slot_cnt == LAST_DATA);
      end else if (slot_cnt == ACK_WAIT) begin
        cnt_d = ACK_HELD;
      end
    end else if (scl_fall && slot_cnt == ACK_HELD) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q    <= '0;
      slot_cnt  <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_q    <= shreg_d;
      slot_cnt  <= cnt_d;
      byte_done <= done_d;
    end
  end
endmodule

// File: rtl/ee_page_addr.sv
module ee_page_addr #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 32,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              incr,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (load) begin
      addr_d = load_val;
    end else if (incr) begin
      addr_d = {addr[ADDR_W-1:PW], addr[PW-1:0] + 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_d;
  end
endmodule

// File: rtl/eeprom_write_front.sv
module eeprom_write_front
  import ee_wr_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          PAGE_BYTES  = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_TYPE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wc_i,
  input  logic              busy_i,
  input  logic [2:0]        hw_sel_i,
  output logic              sda_oe_o,
  output logic              wr_strobe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              commit_o,
  output logic              abort_o
);
  localparam int HI_W = ADDR_W - BYTE_W;
  localparam int CW   = $clog2(BYTE_W + 2);
  localparam logic [CW-1:0] SLOT_ACK_WAIT = CW'(BYTE_W);
  localparam logic [CW-1:0] SLOT_ACK_HELD = CW'(BYTE_W + 1);
  localparam logic [CW-1:0] SLOT_AFTER    = CW'(1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] byte_q;
  logic byte_done;
  logic [CW-1:0] slot_cnt;
  logic [ADDR_W-1:0] cur_addr;

  ee_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ee_bit_shifter #(.BITS(BYTE_W)) u_shifter (
    .clk(clk), .rst_n(rst_int_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .frame_rst(start_det | stop_det), .sda_s(sda_s),
    .byte_q(byte_q), .byte_done(byte_done), .slot_cnt(slot_cnt)
  );

  wr_state_e         state, state_d;
  logic              wc_lat, wc_lat_d;
  logic              ack_en, ack_en_d;
  logic              oe_q, oe_d;
  logic              strobed, strobed_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic              stb_d, commit_d, abort_d;
  logic [ADDR_W-1:0] waddr_d;
  logic [7:0]        wdata_d;
  logic              addr_load, addr_incr;
  logic              sel_match;

  ee_page_addr #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .load(addr_load),
    .load_val({hi_q, byte_q}), .incr(addr_incr), .addr(cur_addr)
  );

  assign sel_match = (byte_q[7:4] == DEV_TYPE) && (byte_q[3:1] == hw_sel_i);

  always_comb begin
    state_d   = state;
    wc_lat_d  = wc_lat;
    ack_en_d  = ack_en;
    oe_d      = oe_q;
    strobed_d = strobed;
    hi_d      = hi_q;
    stb_d     = 1'b0;
    commit_d  = 1'b0;
    abort_d   = 1'b0;
    waddr_d   = wr_addr_o;
    wdata_d   = wr_data_o;
    addr_load = 1'b0;
    addr_incr = 1'b0;

    if (state == ST_SEL || state == ST_AHI || state == ST_ALO) begin
      wc_lat_d = wc_lat | wc_i;
    end

    if (stop_det) begin
      state_d   = ST_IDLE;
      ack_en_d  = 1'b0;
      oe_d      = 1'b0;
      strobed_d = 1'b0;
      if (strobed) begin
        if (state == ST_DATA && slot_cnt == SLOT_AFTER && !busy_i) commit_d = 1'b1;
        else                                                       abort_d  = 1'b1;
      end
    end else if (start_det) begin
      abort_d   = strobed;
      strobed_d = 1'b0;
      ack_en_d  = 1'b0;
      oe_d      = 1'b0;
      wc_lat_d  = wc_i;
      state_d   = busy_i ? ST_IDLE : ST_SEL;
    end else begin
      if (byte_done) begin
        unique case (state)
          ST_SEL: begin
            if (sel_match && !busy_i) begin
              ack_en_d = 1'b1;
              state_d  = byte_q[0] ? ST_RD : ST_AHI;
            end else begin
              ack_en_d = 1'b0;
              state_d  = ST_IDLE;
            end
          end
          ST_AHI: begin
            ack_en_d = 1'b1;
            hi_d     = byte_q[HI_W-1:0];
            state_d  = ST_ALO;
          end
          ST_ALO: begin
            ack_en_d  = 1'b1;
            addr_load = 1'b1;
            state_d   = ST_DATA;
          end
          ST_DATA: begin
            if (!wc_lat && !busy_i) begin
              ack_en_d  = 1'b1;
              stb_d     = 1'b1;
              waddr_d   = cur_addr;
              wdata_d   = byte_q;
              addr_incr = 1'b1;
              strobed_d = 1'b1;
            end else begin
              ack_en_d = 1'b0;
            end
          end
          default: ack_en_d = 1'b0;
        endcase
      end
      if (scl_fall && slot_cnt == SLOT_ACK_WAIT && ack_en) oe_d = 1'b1;
      if (scl_fall && slot_cnt == SLOT_ACK_HELD) begin
        oe_d     = 1'b0;
        ack_en_d = 1'b0;
      end
    end

    if (busy_i) oe_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state       <= ST_IDLE;
      wc_lat      <= 1'b0;
      ack_en      <= 1'b0;
      oe_q        <= 1'b0;
      strobed     <= 1'b0;
      hi_q        <= '0;
      wr_strobe_o <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      commit_o    <= 1'b0;
      abort_o     <= 1'b0;
    end else begin
      state       <= state_d;
      wc_lat      <= wc_lat_d;
      ack_en      <= ack_en_d;
      oe_q        <= oe_d;
      strobed     <= strobed_d;
      hi_q        <= hi_d;
      wr_strobe_o <= stb_d;
      commit_o    <= commit_d;
      abort_o     <= abort_d;
      if (stb_d) begin
        wr_addr_o <= waddr_d;
        wr_data_o <= wdata_d;
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eeprom_write_front_chk.sv
module eeprom_write_front_chk #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 32,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic              sda_oe_o,
  input logic              wr_strobe_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              commit_o,
  input logic              abort_o
);
  logic              seq_valid;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_valid <= 1'b0;
      prev_addr <= '0;
    end else if (commit_o || abort_o) begin
      seq_valid <= 1'b0;
    end else if (wr_strobe_o) begin
      seq_valid <= 1'b1;
      prev_addr <= wr_addr_o;
    end
  end

  assert_busy_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !sda_oe_o);

  assert_busy_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> (!wr_strobe_o && !commit_o));

  assert_commit_abort_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_o && abort_o));

  assert_commit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);

  assert_page_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe_o && seq_valid) |-> (wr_addr_o[ADDR_W-1:PW] == prev_addr[ADDR_W-1:PW]));

  assert_page_low_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe_o && seq_valid) |-> (wr_addr_o[PW-1:0] == PW'(prev_addr[PW-1:0] + 1'b1)));
endmodule

bind eeprom_write_front eeprom_write_front_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .sda_oe_o(sda_oe_o),
  .wr_strobe_o(wr_strobe_o), .wr_addr_o(wr_addr_o),
  .commit_o(commit_o), .abort_o(abort_o)
);

// File: tb/eeprom_write_front_tb_top.sv
module eeprom_write_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 12;

  logic clk, rst_n, scl_m, sda_m, wc, busy;
  logic [2:0] hw;
  logic sda_oe, stb, commit, abort_p;
  logic [15:0] waddr;
  logic [7:0] wdata;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  eeprom_write_front dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .wc_i(wc),
    .busy_i(busy), .hw_sel_i(hw), .sda_oe_o(sda_oe), .wr_strobe_o(stb),
    .wr_addr_o(waddr), .wr_data_o(wdata), .commit_o(commit), .abort_o(abort_p)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int commits_seen = 0, aborts_seen = 0, exp_commits = 0, exp_aborts = 0;
  logic [23:0] exp_q[$];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (stb) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected strobe", {waddr, wdata}, 0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk({waddr, wdata} == e, "R4 strobe addr/data", {waddr, wdata}, e);
        end
      end
      if (commit) commits_seen++;
      if (abort_p) aborts_seen++;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic line, output logic oe);
    wait_n(HALF - 4);
    sda_m = b;
    wait_n(4);
    scl_m = 1'b1;
    wait_n(HALF / 2);
    line = sda_line;
    oe = sda_oe;
    wait_n(HALF / 2);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    logic line, oe;
    bit any_oe;
    any_oe = 0;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(b[i], line, oe);
      if (oe) any_oe = 1;
    end
    chk(!any_oe, "R10 no drive during data bits", any_oe, 0);
    clk_bit(1'b1, line, oe);
    chk((line == 1'b0) == exp_ack, tag, !line, exp_ack);
  endtask

  task automatic send_bits(input int n);
    logic line, oe;
    for (int i = 0; i < n; i++) clk_bit(1'b1, line, oe);
  endtask

  task automatic bus_start();
    wait_n(HALF - 4);
    sda_m = 1'b1;
    wait_n(4);
    scl_m = 1'b1;
    wait_n(HALF / 2);
    sda_m = 1'b0;
    wait_n(HALF / 2);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_n(HALF - 4);
    sda_m = 1'b0;
    wait_n(4);
    scl_m = 1'b1;
    wait_n(HALF / 2);
    sda_m = 1'b1;
    wait_n(HALF);
  endtask

  task automatic settle(input string tag);
    wait_n(20);
    chk(commits_seen == exp_commits, {tag, " commit count"}, commits_seen, exp_commits);
    chk(aborts_seen == exp_aborts, {tag, " abort count"}, aborts_seen, exp_aborts);
    chk(exp_q.size() == 0, {tag, " strobes outstanding"}, exp_q.size(), 0);
  endtask

  task automatic write_head(input logic [7:0] sel, input logic [15:0] a);
    bus_start();
    send_byte(sel, 1, "R1 select ack");
    send_byte(a[15:8], 1, "R3 addr high ack");
    send_byte(a[7:0], 1, "R3 addr low ack");
  endtask

  initial begin
    rst_n = 0; scl_m = 1; sda_m = 1; wc = 0; busy = 0; hw = 3'b000;
    wait_n(5);
    rst_n = 1;
    wait_n(5);
    chk(sda_oe == 0, "R10 reset oe", sda_oe, 0);
    chk(stb == 0 && commit == 0 && abort_p == 0, "R6 reset pulses", {stb, commit, abort_p}, 0);

    // R1 R3 R4 R6: single byte write, commit
    write_head(8'hA0, 16'h0123);
    exp_q.push_back({16'h0123, 8'h5A});
    send_byte(8'h5A, 1, "R4 data ack");
    bus_stop(); exp_commits++;
    settle("R6 byte write");

    // R4 page wrap
    write_head(8'hA0, 16'h003E);
    exp_q.push_back({16'h003E, 8'h11}); send_byte(8'h11, 1, "R4 data ack");
    exp_q.push_back({16'h003F, 8'h22}); send_byte(8'h22, 1, "R4 data ack");
    exp_q.push_back({16'h0020, 8'h33}); send_byte(8'h33, 1, "R4 wrap data ack");
    exp_q.push_back({16'h0021, 8'hC4}); send_byte(8'hC4, 1, "R4 data ack");
    bus_stop(); exp_commits++;
    settle("R4 page write");

    // R5 inhibit during high address byte only
    bus_start();
    send_byte(8'hA0, 1, "R5 select ack");
    wc = 1;
    send_byte(8'h05, 1, "R5 addr high ack under inhibit");
    wc = 0;
    send_byte(8'h00, 1, "R5 addr low ack");
    send_byte(8'h99, 0, "R5 data nack");
    send_byte(8'h98, 0, "R5 data nack");
    bus_stop();
    settle("R5 inhibited");

    // R5 inhibit after address phase has no effect
    write_head(8'hA0, 16'h0540);
    wc = 1;
    exp_q.push_back({16'h0540, 8'h3C}); send_byte(8'h3C, 1, "R5 late inhibit ack");
    bus_stop(); exp_commits++;
    wc = 0;
    settle("R5 late inhibit");

    // R2 mismatched pins
    hw = 3'b101;
    bus_start();
    send_byte(8'hA0, 0, "R2 select nack");
    send_byte(8'h00, 0, "R2 follow nack");
    bus_stop();
    settle("R2 mismatch");
    // R1 matching pins
    write_head(8'hAA, 16'h1234);
    exp_q.push_back({16'h1234, 8'h81}); send_byte(8'h81, 1, "R1 data ack");
    bus_stop(); exp_commits++;
    settle("R1 pin match");
    hw = 3'b000;

    // R6 stop in wrong slot
    write_head(8'hA0, 16'h0200);
    exp_q.push_back({16'h0200, 8'h44}); send_byte(8'h44, 1, "R6 data ack");
    send_bits(3);
    bus_stop(); exp_aborts++;
    settle("R6 misplaced stop");

    // R6 stop right after address: nothing strobed
    write_head(8'hA0, 16'h0300);
    bus_stop();
    settle("R6 stop after address");

    // R7 repeated start
    write_head(8'hA0, 16'h0300);
    exp_q.push_back({16'h0300, 8'h55}); send_byte(8'h55, 1, "R7 data ack");
    bus_start(); exp_aborts++;
    send_byte(8'hA0, 1, "R7 new select ack");
    send_byte(8'h04, 1, "R7 addr ack");
    send_byte(8'h00, 1, "R7 addr ack");
    exp_q.push_back({16'h0400, 8'h77}); send_byte(8'h77, 1, "R7 data ack");
    bus_stop(); exp_commits++;
    settle("R7 restart");

    // R9 read select
    bus_start();
    send_byte(8'hA1, 1, "R9 read select ack");
    send_byte(8'hFF, 0, "R9 following byte ignored");
    bus_stop();
    settle("R9 read");

    // R8 busy
    busy = 1;
    bus_start();
    send_byte(8'hA0, 0, "R8 select nack while busy");
    send_byte(8'h00, 0, "R8 follow nack while busy");
    bus_stop();
    busy = 0;
    settle("R8 busy");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule